// File: doc/BRIEF.md
# Packed Colour Lookup Table with Channel Expansion

This block holds a 256-entry colour lookup table as 128 words of 32 bits, each word carrying two 16-bit colour entries. A register bus writes and reads the raw words through a 512-byte window. A pixel port takes an 8-bit colour index and returns a 24-bit RGB colour one cycle later. Each 5-bit channel of the selected entry is widened to 8 bits.

Software loads the table over the bus. The display path then streams indices into the pixel port, one per cycle, and gets one colour back per cycle. A static channel-order input sets whether red or blue leaves on the upper byte of the colour. The top bit of each entry is kept in storage and reads back over the bus, but it has no effect on the colour.

Top module: `clut_palette`

## Requirements
- R1: The window spans byte offsets 0x200 to 0x3FF on `bus_addr_i`. The byte offset 0x200 + 4k selects word k (k = 0..127), and the two low address bits are ignored. A write outside the window changes no entry. A read outside the window returns zero.
- R2: A bus read of a word returns, on the following cycle, all 32 bits exactly as last written, including bits 15 and 31.
- R3: Colour index i selects word i>>1. Bit 0 of i picks the half: 0 picks bits [15:0] and 1 picks bits [31:16].
- R4: In a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. With `bgr_i` low the colour output is red on [23:16], green on [15:8] and blue on [7:0].
- R5: Each 5-bit channel becomes the upper 5 bits of its output byte, and the low 3 bits of that byte are zero.
- R6: Bit 15 of an entry has no effect on the colour output.
- R7: With `bgr_i` high, red and blue trade places: blue goes to [23:16] and red to [7:0]. `bgr_i` is sampled together with the index.
- R8: The pixel port has one cycle of latency. `pix_valid_o` repeats `pix_valid_i` one cycle later, and `pix_rgb_o` shows the colour of the index presented in the previous cycle. A bus read also returns its data one cycle after the address.
- R9: If a bus write and a lookup or bus read target the same word in the same cycle, the old contents are returned. The new contents appear from the next access onward.
- R10: Reset clears every word to zero. After reset, `bus_rdata_o`, `pix_rgb_o` and `pix_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 12 | Bus byte offset |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, one cycle after the address |
| pix_valid_i | input | 1 | Index qualifier |
| pix_idx_i | input | 8 | Colour index |
| bgr_i | input | 1 | Swap red and blue on the colour output |
| pix_valid_o | output | 1 | Delayed qualifier |
| pix_rgb_o | output | 24 | Expanded colour |

## Verification
Lookups are driven with entries that light one channel at a time. These show whether the field positions and the output byte order are right, and whether the swap moves only red and blue. Entries with all fields full and with all fields at 1 expose expansion that replicates bits instead of filling with zeros. An irregular mixed pattern catches swapped field boundaries. Entries with the top bit set, indices 254/255 at the window end and accesses just outside the window separate half-select, intensity and decode faults. A write and a lookup to the same word in the same cycle tell old-data from write-through behaviour.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CH_IN_W  = 5;
  localparam int CH_OUT_W = 8;
  localparam int N_CH     = 3;
  localparam int ENT_W    = 16;
  localparam int WORD_W   = 2 * ENT_W;
  localparam int PAD_W    = CH_OUT_W - CH_IN_W;
  localparam int RGB_W    = N_CH * CH_OUT_W;
endpackage

// File: rtl/clut_bus_dec.sv
module clut_bus_dec #(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h200,
  parameter int WORDS    = 128,
  localparam int WIDX_W  = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [WIDX_W-1:0] widx_o
);
  localparam int SPAN = WORDS * 4;
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(WIN_BASE + SPAN);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] offs;
  logic            unused_offs;

  assign addr_x = {1'b0, addr_i};
  assign offs   = addr_x - LO;
  assign hit_o  = (addr_x >= LO) && (addr_x < HI);
  assign widx_o = offs[WIDX_W+1:2];
  assign unused_offs = ^{offs[ADDR_W:WIDX_W+2], offs[1:0]};
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int WORDS   = 128,
  parameter int WORD_W  = 32,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIDX_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WIDX_W-1:0] raddr_a_i,
  output logic [WORD_W-1:0] rdata_a_o,
  input  logic [WIDX_W-1:0] raddr_b_i,
  output logic [WORD_W-1:0] rdata_b_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < WORDS; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // Registered reads sample pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_a_o <= '0;
      rdata_b_o <= '0;
    end else begin
      rdata_a_o <= mem_q[raddr_a_i];
      rdata_b_o <= mem_q[raddr_b_i];
    end
  end

  p_wr_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

  p_old_on_collide_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && raddr_b_i == waddr_i && mem_q[waddr_i] != wdata_i)
      |=> rdata_b_o != mem_q[$past(raddr_b_i)]);
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              upper_i,
  input  logic              bgr_i,
  output logic [RGB_W-1:0]  rgb_o
);
  logic [ENT_W-1:0]    entry;
  logic [CH_OUT_W-1:0] ch [N_CH];
  logic                unused_ibit;

  assign entry       = upper_i ? word_i[WORD_W-1:ENT_W] : word_i[ENT_W-1:0];
  assign unused_ibit = entry[ENT_W-1];

  // Channel 0 = red, 1 = green, 2 = blue
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch[c] = {entry[c*CH_IN_W +: CH_IN_W], {PAD_W{1'b0}}};
  end

  assign rgb_o = bgr_i ? {ch[2], ch[1], ch[0]} : {ch[0], ch[1], ch[2]};

  always_comb begin
    p_low_zero_r5: assert (rgb_o[PAD_W-1:0] == '0 &&
                           rgb_o[CH_OUT_W +: PAD_W] == '0 &&
                           rgb_o[2*CH_OUT_W +: PAD_W] == '0)
      else $error("low pad bits set");
  end
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h200,
  parameter int IDX_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              pix_valid_i,
  input  logic [IDX_W-1:0]  pix_idx_i,
  input  logic              bgr_i,
  output logic              pix_valid_o,
  output logic [RGB_W-1:0]  pix_rgb_o
);
  localparam int WORDS  = 1 << (IDX_W - 1);
  localparam int WIDX_W = IDX_W - 1;

  logic              bus_hit;
  logic [WIDX_W-1:0] bus_widx;
  logic [WORD_W-1:0] bus_word;
  logic [WORD_W-1:0] pix_word;
  logic              rd_hit_q;
  logic              upper_q;
  logic              bgr_q;

  clut_bus_dec #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WORDS   (WORDS)
  ) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (bus_hit),
    .widx_o(bus_widx)
  );

  clut_store #(
    .WORDS (WORDS),
    .WORD_W(WORD_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i & bus_hit),
    .waddr_i  (bus_widx),
    .wdata_i  (bus_wdata_i),
    .raddr_a_i(bus_widx),
    .rdata_a_o(bus_word),
    .raddr_b_i(pix_idx_i[IDX_W-1:1]),
    .rdata_b_o(pix_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hit_q    <= 1'b0;
      upper_q     <= 1'b0;
      bgr_q       <= 1'b0;
      pix_valid_o <= 1'b0;
    end else begin
      rd_hit_q    <= bus_hit & ~bus_we_i;
      upper_q     <= pix_idx_i[0];
      bgr_q       <= bgr_i;
      pix_valid_o <= pix_valid_i;
    end
  end

  assign bus_rdata_o = rd_hit_q ? bus_word : '0;

  clut_expand u_exp (
    .word_i (pix_word),
    .upper_i(upper_q),
    .bgr_i  (bgr_q),
    .rgb_o  (pix_rgb_o)
  );

  p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pix_valid_o == $past(pix_valid_i));

  p_miss_reads_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_hit |=> bus_rdata_o == '0);
endmodule

// File: tb/clut_palette_test.sv
module clut_palette_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pv = 1'b0;
  logic [7:0]  idx = '0;
  logic        bgr = 1'b0;
  logic        pv_o;
  logic [23:0] rgb;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  clut_palette uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pix_valid_i(pv), .pix_idx_i(idx), .bgr_i(bgr),
    .pix_valid_o(pv_o), .pix_rgb_o(rgb)
  );

  // {word data, index, bgr, expected rgb}
  localparam logic [64:0] VEC [9] = '{
    {32'h0000_7FFF, 8'd0,   1'b0, 24'hF8F8F8},
    {32'h001F_0000, 8'd3,   1'b0, 24'hF80000},
    {32'h001F_0000, 8'd3,   1'b1, 24'h0000F8},
    {32'h83E0_0000, 8'd11,  1'b0, 24'h00F800},
    {32'h0000_FC00, 8'd254, 1'b0, 24'h0000F8},
    {32'hFC00_0000, 8'd255, 1'b1, 24'hF80000},
    {32'h0000_0421, 8'd128, 1'b0, 24'h080808},
    {32'h2A55_0000, 8'd129, 1'b0, 24'hA89050},
    {32'h2A55_0000, 8'd129, 1'b1, 24'h5090A8}
  };

  function automatic logic [23:0] expect_rgb(logic [31:0] w, logic up, logic sw);
    logic [15:0] e;
    e = up ? w[31:16] : w[15:0];
    return sw ? {e[14:10], 3'b0, e[9:5], 3'b0, e[4:0], 3'b0}
              : {e[4:0], 3'b0, e[9:5], 3'b0, e[14:10], 3'b0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a);
    addr = a; we = 1'b0;
    @(negedge clk);
  endtask

  task automatic look(logic [7:0] i, logic sw);
    idx = i; bgr = sw; pv = 1'b1;
    @(negedge clk);
    pv = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 rdata", rdata, 32'h0);
    check("R10 rgb", {8'h0, rgb}, 32'h0);
    check("R10 valid", {31'h0, pv_o}, 32'h0);
    bus_rd(12'h3FC);
    check("R10 word127", rdata, 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 9; v++) begin
      logic [31:0] d;
      logic [7:0]  i;
      logic        s;
      logic [23:0] e;
      {d, i, s, e} = VEC[v];
      bus_wr(12'h200 + {3'b0, i[7:1], 2'b00}, d);
      look(i, s);
      check($sformatf("R4/R7 vec%0d", v), {8'h0, rgb}, {8'h0, e});
      check($sformatf("R5 model vec%0d", v), {8'h0, e}, {8'h0, expect_rgb(d, i[0], s)});
      bus_rd(12'h200 + {3'b0, i[7:1], 2'b00});
      check($sformatf("R2 vec%0d", v), rdata, d);
    end

    // R6: only intensity bit differs
    bus_wr(12'h220, 32'h8123_0123);
    look(8'd16, 1'b0);
    check("R6 low", {8'h0, rgb}, {8'h0, expect_rgb(32'h0123, 1'b0, 1'b0)});
    look(8'd17, 1'b0);
    check("R6 high", {8'h0, rgb}, {8'h0, expect_rgb(32'h0123, 1'b0, 1'b0)});

    // R1: outside window and low address bits
    bus_wr(12'h1FC, 32'hDEAD_BEEF);
    bus_wr(12'h400, 32'hCAFE_F00D);
    bus_rd(12'h200);
    check("R1 word0 kept", rdata, 32'h0000_7FFF);
    bus_rd(12'h3FC);
    check("R1 word127 kept", rdata, 32'hFC00_0000);
    bus_rd(12'h1FC);
    check("R1 miss below", rdata, 32'h0);
    bus_rd(12'h400);
    check("R1 miss above", rdata, 32'h0);
    bus_wr(12'h207, 32'h1234_5678);
    bus_rd(12'h204);
    check("R1 low bits ignored", rdata, 32'h1234_5678);

    // R8: valid latency
    idx = 8'd2; pv = 1'b1;
    @(negedge clk);
    check("R8 valid high", {31'h0, pv_o}, 32'h1);
    check("R8 rgb", {8'h0, rgb}, {8'h0, expect_rgb(32'h1234_5678, 1'b0, 1'b0)});
    pv = 1'b0;
    @(negedge clk);
    check("R8 valid low", {31'h0, pv_o}, 32'h0);

    // R9: collision returns old word
    bus_wr(12'h228, 32'h0000_001F);
    addr = 12'h228; wdata = 32'h0000_7C00; we = 1'b1; idx = 8'd20; bgr = 1'b0;
    @(negedge clk);
    we = 1'b0;
    check("R9 old on lookup", {8'h0, rgb}, 32'h00F8_0000);
    idx = 8'd20;
    @(negedge clk);
    check("R9 new next", {8'h0, rgb}, 32'h0000_00F8);
    check("R9 bus new", rdata, 32'h0000_7C00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule